// File: doc/BRIEF.md
# Serial Converter Port Slave

This block is the digital front of an eight-channel, 12-bit sampling converter, as seen from its four-wire serial port. A host lowers an active-low select, runs the serial clock in groups of 16 cycles, and sends a control byte on the data input during each group. On each falling serial clock edge the block shifts out one bit of a 16-bit word: four zero bits, then a 12-bit result in straight binary, most significant bit first. The result comes from a parallel input. It is captured when the conversion moves from track to hold.

The block runs on one fast system clock. The select, serial clock and data input pass through a synchronizer, and edges are found by comparing the synchronized level with its previous value. The block drives a data bit plus an output enable, a track flag, a hold flag, a power-down flag, and a channel-select bus for an external analog multiplexer. The channel address is pipelined: the address sent in one conversion picks the input for the next conversion. Several conversions may follow each other in one select frame.

Top module: `adc_serial_slave`

## Requirements
- R1: Serial clock edges are counted in groups of 16 within a frame. Raising the select clears the count, so the next frame starts again with its first leading zero.
- R2: `sdo_oe` is 1 while the select is low and 0 while it is high. Serial clock and data-input activity while the select is high changes no output and no stored address.
- R3: After falling edges 1 to 4 of each conversion, `sdo` is 0.
- R4: After falling edge k of a conversion (k = 5 to 16), `sdo` carries result bit 16-k. The most significant bit therefore comes after edge 5.
- R5: The control byte is sampled on rising edges 1 to 8 of each conversion, byte bit 7 first. Byte bits 5:3 form the channel address (bit 5 is the address MSB), and code n selects input n. All other bits, and all data on rising edges 9 to 16, are ignored.
- R6: `chan_sel` resets to 0. It takes the address of a conversion on that conversion's 16th rising edge and does not change at any other time. A frame's first conversion therefore uses the address from the previous conversion.
- R7: `track` is 1 from falling edge 1 until falling edge 4 of a conversion. `hold` is 1 from falling edge 4 until falling edge 16. The two are never 1 together and are both 0 while the select is high.
- R8: `pwr_dn` is 1 while the select is high and from falling edge 16 of a conversion until falling edge 1 of the next. It is 0 between the select falling with the clock high and the first falling clock edge.
- R9: When the select falls while the serial clock is already low, that select edge counts as falling edge 1.
- R10: The result is taken from `conv_data` at falling edge 4. Later changes on `conv_data` during that conversion do not alter the bits shifted out.
- R11: A frame can hold several back-to-back conversions. Each conversion repeats the zero/result pattern, the phase sequence and the address pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low frame select (asynchronous to clk) |
| sclk | input | 1 | Serial clock (asynchronous to clk) |
| sdi | input | 1 | Serial control data input |
| conv_data | input | 12 | Parallel conversion result from the converter core |
| sdo | output | 1 | Serial data output bit |
| sdo_oe | output | 1 | Output enable for the data pin; 0 means high impedance |
| track | output | 1 | Sample capacitor tracking the selected input |
| hold | output | 1 | Sample held, conversion in progress |
| pwr_dn | output | 1 | Converter powered down |
| chan_sel | output | 3 | Input channel select for the analog multiplexer |

## Verification
Two situations are hard to reach from the ports. The first is a select falling while the serial clock is already low. The stimulus parks the clock low while the select is still high, which the block must ignore, and then lowers the select alone. The correct bit alignment and an immediate `track` confirm that the select edge was counted as the first clock fall. The second is the one-conversion address lag across back-to-back conversions and across frames. The bench runs a two-conversion frame with distinct addresses and different results, and it scrambles `conv_data` right after each capture point to show that the shifted-out value was latched.

// File: rtl/adcs_pkg.sv
// Shared types for the serial converter port slave.
// Assumes: nothing beyond IEEE 1800-2017.
package adcs_pkg;
    // Converter phase as reported to the analog side and the status pins.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // selected, waiting for first clock fall
        PH_TRACK = 2'd1,   // acquiring input
        PH_HOLD  = 2'd2,   // converting / shifting result
        PH_PDN   = 2'd3    // powered down
    } phase_e;
endpackage

// File: rtl/adcs_sync.sv
// Multi-bit level synchronizer into the system clock domain.
// Assumes: each bit is independent; STAGES >= 2; RST_VAL gives idle levels.
module adcs_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    // Shift each input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < int'(STAGES); s++) pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/adcs_sequencer.sv
// Frame sequencer: detects select and serial clock edges, counts falling and
// rising edges per 16-cycle conversion, derives the phase, captures the
// channel address and applies it at the end of the conversion.
// Assumes: inputs already synchronized; host obeys select-to-clock setup.
module adcs_sequencer
    import adcs_pkg::*;
#(
    parameter int unsigned CONV_CLKS  = 16,
    parameter int unsigned TRACK_CLKS = 3,
    parameter int unsigned CTRL_BITS  = 8,
    parameter int unsigned ADDR_LSB   = 3,
    parameter int unsigned CH_W       = 3,
    parameter int unsigned IDX_W      = $clog2(CONV_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_lvl,
    input  logic             sclk_lvl,
    input  logic             sdi_lvl,
    output logic             fall_ev,
    output logic [IDX_W-1:0] fall_n,
    output phase_e           phase,
    output logic [CH_W-1:0]  chan_sel
);
    localparam logic [IDX_W-1:0] LAST_EDGE  = IDX_W'(CONV_CLKS);
    localparam logic [IDX_W-1:0] TRACK_LAST = IDX_W'(TRACK_CLKS);

    logic             cs_q, sclk_q;
    logic             active, cs_fall, sclk_fall, sclk_rise, rise_ev;
    logic [IDX_W-1:0] fall_idx, rise_cnt, rise_n;
    logic [CH_W-1:0]  addr_next;

    assign active    = ~cs_lvl;
    assign cs_fall   = cs_q & ~cs_lvl;
    assign sclk_fall = sclk_q & ~sclk_lvl;
    assign sclk_rise = ~sclk_q & sclk_lvl;
    // A select fall with the clock already low stands in for falling edge 1.
    assign fall_ev   = active & (sclk_fall | (cs_fall & ~sclk_lvl));
    assign rise_ev   = active & sclk_rise;
    assign fall_n    = (fall_idx == '0 || fall_idx == LAST_EDGE)
                       ? IDX_W'(1) : fall_idx + IDX_W'(1);
    assign rise_n    = rise_cnt + IDX_W'(1);

    // Remember previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_lvl;
            sclk_q <= sclk_lvl;
        end
    end

    // Edge counters; cleared whenever the select is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            fall_idx <= '0;
            rise_cnt <= '0;
        end else begin
            if (fall_ev) fall_idx <= fall_n;
            if (rise_ev) rise_cnt <= (rise_n == LAST_EDGE) ? '0 : rise_n;
        end
    end

    // Capture address bits MSB first and apply them at the conversion end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_next <= '0;
            chan_sel  <= '0;
        end else if (rise_ev) begin
            for (int j = 0; j < int'(CH_W); j++) begin
                if (rise_n == IDX_W'(CTRL_BITS - ADDR_LSB - j))
                    addr_next[j] <= sdi_lvl;
            end
            if (rise_n == LAST_EDGE) chan_sel <= addr_next;
        end
    end

    // Phase decode from the falling-edge index.
    always_comb begin
        if (!active)                    phase = PH_PDN;
        else if (fall_idx == '0)        phase = PH_IDLE;
        else if (fall_idx <= TRACK_LAST) phase = PH_TRACK;
        else if (fall_idx == LAST_EDGE) phase = PH_PDN;
        else                            phase = PH_HOLD;
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fall_idx <= LAST_EDGE);                                        // R1
    AST_CHAN_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_ev && rise_n == LAST_EDGE) |=> $stable(chan_sel));      // R6
    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> (fall_idx == '0 && rise_cnt == '0));                // R1
endmodule

// File: rtl/adcs_shifter.sv
// Output shifter: drives leading zeros, latches the result at the start of
// hold, then shifts it out MSB first on each falling-edge event.
// Assumes: fall_n is the 1-based index of the falling edge in progress.
module adcs_shifter #(
    parameter int unsigned RES_W      = 12,
    parameter int unsigned LEAD_ZEROS = 4,
    parameter int unsigned IDX_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             fall_ev,
    input  logic [IDX_W-1:0] fall_n,
    input  logic [RES_W-1:0] conv_data,
    output logic             sdo
);
    localparam logic [IDX_W-1:0] CAPTURE_EDGE = IDX_W'(LEAD_ZEROS);

    logic [RES_W-1:0] sr;

    // Leading zeros, capture at hold start, then MSB-first shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0;
            sr  <= '0;
        end else if (!active) begin
            sdo <= 1'b0;
        end else if (fall_ev) begin
            if (fall_n <= CAPTURE_EDGE) begin
                sdo <= 1'b0;
                if (fall_n == CAPTURE_EDGE) sr <= conv_data;
            end else begin
                sdo <= sr[RES_W-1];
                sr  <= {sr[RES_W-2:0], 1'b0};
            end
        end
    end

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fall_ev) |=> $stable(sr));                         // R10
endmodule

// File: rtl/adc_serial_slave.sv
// Top of the serial converter port slave: synchronizes the pins, sequences
// the frame and drives the serial output and converter status.
// Assumes: clk runs at least 8x faster than sclk; one system clock domain.
module adc_serial_slave
    import adcs_pkg::*;
#(
    parameter int unsigned RES_W       = 12,
    parameter int unsigned LEAD_ZEROS  = 4,
    parameter int unsigned CH_W        = 3,
    parameter int unsigned CTRL_BITS   = 8,
    parameter int unsigned ADDR_LSB    = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic [RES_W-1:0] conv_data,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             track,
    output logic             hold,
    output logic             pwr_dn,
    output logic [CH_W-1:0]  chan_sel
);
    localparam int unsigned CONV_CLKS  = LEAD_ZEROS + RES_W;
    localparam int unsigned TRACK_CLKS = LEAD_ZEROS - 1;
    localparam int unsigned IDX_W      = $clog2(CONV_CLKS + 1);

    logic [2:0]       pins_s;
    logic             fall_ev;
    logic [IDX_W-1:0] fall_n;
    phase_e           phase;

    adcs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({cs_n, sclk, sdi}), .dout(pins_s)
    );

    adcs_sequencer #(
        .CONV_CLKS(CONV_CLKS), .TRACK_CLKS(TRACK_CLKS), .CTRL_BITS(CTRL_BITS),
        .ADDR_LSB(ADDR_LSB), .CH_W(CH_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_lvl(pins_s[2]), .sclk_lvl(pins_s[1]),
        .sdi_lvl(pins_s[0]), .fall_ev(fall_ev), .fall_n(fall_n),
        .phase(phase), .chan_sel(chan_sel)
    );

    adcs_shifter #(.RES_W(RES_W), .LEAD_ZEROS(LEAD_ZEROS), .IDX_W(IDX_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .active(~pins_s[2]), .fall_ev(fall_ev),
        .fall_n(fall_n), .conv_data(conv_data), .sdo(sdo)
    );

    // Status decode for the pins.
    assign sdo_oe = ~pins_s[2];
    assign track  = (phase == PH_TRACK);
    assign hold   = (phase == PH_HOLD);
    assign pwr_dn = (phase == PH_PDN);

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({track, hold, pwr_dn}) <= 1);                       // R7
    AST_TRACK_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        track |-> !sdo);                                               // R3
    AST_DESELECT_PDN: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> (pwr_dn && !track && !hold));                      // R8
endmodule

// File: tb/adc_serial_slave_test.sv
// Directed bench for the serial converter port slave.
module adc_serial_slave_test;
    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk, sdi;
    logic [11:0] conv_data;
    logic        sdo, sdo_oe, track, hold, pwr_dn;
    logic [2:0]  chan_sel;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    adc_serial_slave uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .conv_data(conv_data), .sdo(sdo), .sdo_oe(sdo_oe), .track(track),
        .hold(hold), .pwr_dn(pwr_dn), .chan_sel(chan_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One select frame of nconv conversions; checks every falling edge.
    task automatic run_frame(input int nconv, input bit low_start,
                             input logic [7:0] c0, input logic [7:0] c1,
                             input logic [11:0] d0, input logic [11:0] d1,
                             input logic [2:0] chan_before);
        logic [7:0]  ctrl;
        logic [11:0] dat;
        logic [2:0]  exp_ch;
        if (low_start) begin
            sclk = 1'b0;           // clock parked low while still deselected
            tick(6);
        end else begin
            sclk = 1'b1;
            cs_n = 1'b0;
            tick(6);
            chk(pwr_dn == 1'b0 && track == 1'b0, "R8 idle-before-first-fall", pwr_dn, 0);
            chk(sdo_oe == 1'b1 && sdo == 1'b0, "R2 enable-on-select", sdo_oe, 1);
        end
        for (int k = 0; k < nconv; k++) begin
            ctrl      = (k == 0) ? c0 : c1;
            dat       = (k == 0) ? d0 : d1;
            exp_ch    = (k == 0) ? chan_before : c0[5:3];
            conv_data = dat;
            for (int i = 1; i <= 16; i++) begin
                if (k == 0 && i == 1 && low_start) cs_n = 1'b0;
                else sclk = 1'b0;
                tick(6);
                if (i <= 4)
                    chk(sdo == 1'b0, "R3 leading-zero", sdo, 0);
                else
                    chk(sdo == dat[16-i], "R4 result-bit", sdo, dat[16-i]);
                chk(track == (i <= 3), (low_start && k == 0 && i == 1)
                    ? "R9 select-as-first-fall" : "R7 track", track, (i <= 3));
                chk(hold == (i >= 4 && i <= 15), "R7 hold", hold, (i >= 4 && i <= 15));
                chk(pwr_dn == (i == 16), "R8 pdn-after-16", pwr_dn, (i == 16));
                if (i == 1)
                    chk(chan_sel == exp_ch, (k == 0) ? "R6 pipelined-chan" : "R11 chan-in-cont",
                        chan_sel, exp_ch);
                if (i == 4) conv_data = ~dat;   // R10: scramble after capture
                sdi  = (i <= 8) ? ctrl[8-i] : 1'b1;
                sclk = 1'b1;
                tick(6);
            end
        end
        cs_n = 1'b1;
        tick(6);
        exp_ch = (nconv == 1) ? c0[5:3] : c1[5:3];
        chk(chan_sel == exp_ch, "R5 address-decode", chan_sel, exp_ch);
        chk(sdo_oe == 1'b0, "R2 hiz-on-deselect", sdo_oe, 0);
        chk(pwr_dn == 1'b1 && track == 1'b0 && hold == 1'b0, "R8 pdn-deselect", pwr_dn, 1);
        sdi = 1'b0;
    endtask

    task automatic t_reset();
        chk(sdo_oe == 1'b0, "R2 reset-oe", sdo_oe, 0);
        chk(pwr_dn == 1'b1, "R8 reset-pdn", pwr_dn, 1);
        chk(chan_sel == 3'd0, "R6 reset-chan", chan_sel, 0);
        chk(track == 1'b0 && hold == 1'b0, "R7 reset-phase", track, 0);
    endtask

    task automatic t_single();
        // junk in ignored bits, address 101
        run_frame(1, 1'b0, 8'b11_101_111, 8'h00, 12'hA5C, 12'h000, 3'd0);
        run_frame(1, 1'b0, 8'b00_010_000, 8'h00, 12'hFFF, 12'h000, 3'd5);
    endtask

    task automatic t_continuous();
        run_frame(2, 1'b0, 8'b00_011_000, 8'b10_110_001, 12'h000, 12'h801, 3'd2);
    endtask

    task automatic t_low_start();
        run_frame(1, 1'b1, 8'b01_111_010, 8'h00, 12'h3C7, 12'h000, 3'd6);
        sclk = 1'b1;
        tick(6);
    endtask

    task automatic t_ignored();
        // Toggle the clock with data high while deselected (R2).
        for (int i = 0; i < 20; i++) begin
            sdi  = 1'b1;
            sclk = 1'b0;
            tick(4);
            chk(pwr_dn == 1'b1 && sdo_oe == 1'b0, "R2 ignored-clock", pwr_dn, 1);
            sclk = 1'b1;
            tick(4);
        end
        chk(chan_sel == 3'd7, "R2 chan-unchanged", chan_sel, 7);
        sdi = 1'b0;
        // Fresh frame still begins with leading zeros (R1).
        run_frame(1, 1'b0, 8'b00_001_000, 8'h00, 12'h5A5, 12'h000, 3'd7);
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0; conv_data = '0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_single();
        t_continuous();
        t_low_start();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule